// File: doc/BRIEF.md
# Byte-Streaming Debug Data Register

This block is the target-side data register of a byte-oriented debug channel reached through a JTAG TAP. It is active only while the debug instruction is selected. During Shift-DR it assembles the bits arriving on TDI into bytes and hands each complete byte to a command engine. At the same time it serializes response bytes from a response engine onto TDO. Delivery is tied to the eighth shifted bit, not to Update-DR. Traffic therefore behaves as a continuous stream inside one scan. A host sends a command and its operands in one DR scan. It collects the status byte and any response data in a later scan.

Each scan starts on a byte boundary because Capture-DR clears the bit counter. Update-DR does nothing. A response byte is consumed only when its first bit is actually shifted. A scan that ends early therefore never loses a queued byte. When no response byte is offered, the filler value 0xAA goes out instead. The TAP controller, the instruction register and the meaning of the bytes all sit outside this block.

Top module: `dbgbyte_dr`

## Requirements
- R1: After reset the receive strobe `rx_valid` and `tx_ready` are low, and with `tx_valid` low `tdo` shows bit 0 of the 0xAA filler, which is 0.
- R2: With `sel` and `shift_dr` high, TDI bits are taken at each rising TCK edge, least significant bit first. After the eighth such edge, `rx_valid` is high for exactly one cycle and `rx_data` holds the assembled byte.
- R3: `capture_dr` with `sel` high resets the bit count. Bits from a partial byte before it are discarded and produce no `rx_valid`.
- R4: `update_dr` has no effect. A byte split across an Update-DR pulse is still assembled and serialized intact.
- R5: Response bytes appear on `tdo` least significant bit first, one bit per shift cycle. `tdo` shows the bit that the next rising edge shifts.
- R6: When `tx_valid` is low at the first bit of a byte, the byte 0xAA is shifted out.
- R7: `tx_ready` is high only in a shift cycle that carries the first bit of a byte. A byte is consumed when `tx_valid` and `tx_ready` are both high at a rising edge. `tx_data` must be held until then.
- R8: With `sel` low, shifting has no effect: no `rx_valid`, no consumption from the transmit port, and the bit count is kept.
- R9: In continuous shifting, the cycle in which `rx_valid` is high is also the cycle in which `tx_ready` is high for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Debug instruction is loaded in the instruction register |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR (ignored) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | A response byte is offered |
| tx_data | input | 8 | Offered response byte |
| tx_ready | output | 1 | The offered byte is taken at the next rising edge |

Back-pressure: the receive side has no ready signal, because the scan clock cannot be stalled. The sink must accept every strobe. The transmit side is valid/ready, and the source may keep `tx_valid` low for as long as it likes.

## Verification
In continuous shifting, the completion of a received byte and the take of the next response byte fall in the same cycle. The bench shifts multi-byte scans while a queue of response bytes is offered. A scoreboard checks every strobed receive byte against what was driven on TDI. It also checks every eight-bit group seen on TDO against the offered bytes followed by 0xAA filler. A loss or duplicate at that shared boundary shows up as a miscompare on one of the two streams.

// File: rtl/dbgbyte_pkg.sv
package dbgbyte_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CAPT  = 2'd1,
    PH_SHIFT = 2'd2
  } dr_phase_e;

  function automatic dr_phase_e decode_phase(input logic sel, input logic capt,
                                             input logic shft);
    if (!sel)      return PH_IDLE;
    else if (capt) return PH_CAPT;
    else if (shft) return PH_SHIFT;
    else           return PH_IDLE;
  endfunction
endpackage

// File: rtl/dbgbyte_bitcnt.sv
module dbgbyte_bitcnt #(
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      step,
  output logic [$clog2(BYTE_W)-1:0] cnt,
  output logic                      at_first,
  output logic                      at_last
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (step) begin
      if (cnt == LAST)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  assign at_first = (cnt == '0);
  assign at_last  = (cnt == LAST);
endmodule

// File: rtl/dbgbyte_rx.sv
module dbgbyte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              last,
  input  logic              bit_in,
  output logic              valid,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_shreg;

  assign next_shreg = {bit_in, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= step && last;
      if (step) begin
        shreg <= next_shreg;
        if (last) data <= next_shreg;
      end
    end
  end
endmodule

// File: rtl/dbgbyte_tx.sv
module dbgbyte_tx #(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              first,
  input  logic              head_valid,
  input  logic [BYTE_W-1:0] head_data,
  output logic              ready,
  output logic              bit_out
);
  localparam int REST_W = BYTE_W - 1;

  logic [BYTE_W-1:0] head;
  logic [REST_W-1:0] rest;

  assign head    = head_valid ? head_data : FILL;
  assign ready   = step && first;
  assign bit_out = first ? head[0] : rest[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rest <= FILL[BYTE_W-1:1];
    else if (step) begin
      if (first)           rest <= head[BYTE_W-1:1];
      else                 rest <= {1'b0, rest[REST_W-1:1]};
    end
  end
endmodule

// File: rtl/dbgbyte_dr.sv
module dbgbyte_dr
  import dbgbyte_pkg::*;
#(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL   = 8'hAA
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready
);
  localparam int CNT_W = $clog2(BYTE_W);

  dr_phase_e         phase;
  logic              do_clear;
  logic              do_step;
  logic [CNT_W-1:0]  bit_cnt;
  logic              first_bit;
  logic              last_bit;
  logic              upd_unused;

  assign phase      = decode_phase(sel, capture_dr, shift_dr);
  assign do_clear   = (phase == PH_CAPT);
  assign do_step    = (phase == PH_SHIFT);
  assign upd_unused = update_dr;

  dbgbyte_bitcnt #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(tck), .rst_n(trst_n), .clear(do_clear), .step(do_step),
    .cnt(bit_cnt), .at_first(first_bit), .at_last(last_bit)
  );

  dbgbyte_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(tck), .rst_n(trst_n), .step(do_step), .last(last_bit),
    .bit_in(tdi), .valid(rx_valid), .data(rx_data)
  );

  dbgbyte_tx #(.BYTE_W(BYTE_W), .FILL(FILL)) u_tx (
    .clk(tck), .rst_n(trst_n), .step(do_step), .first(first_bit),
    .head_valid(tx_valid), .head_data(tx_data),
    .ready(tx_ready), .bit_out(tdo)
  );
endmodule

// File: rtl/dbgbyte_dr_chk.sv
module dbgbyte_dr_chk #(
  parameter int BYTE_W = 8
) (
  input logic                      tck,
  input logic                      trst_n,
  input logic                      sel,
  input logic                      capture_dr,
  input logic                      shift_dr,
  input logic                      update_dr,
  input logic                      rx_valid,
  input logic                      tx_ready,
  input logic [$clog2(BYTE_W)-1:0] bit_cnt
);
  logic seen;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R2: a receive strobe lasts one cycle
  assert_rx_pulse_R2: assert property (@(posedge tck) disable iff (!trst_n)
    rx_valid |=> !rx_valid);

  // R8: a strobe only follows a selected shift cycle
  assert_rx_needs_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (seen && rx_valid) |-> $past(sel && shift_dr));

  // R3: after a capture the count restarts and no byte is strobed
  assert_capture_restart_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture_dr) |=> (bit_cnt == '0 && !rx_valid));

  // R4: an Update-DR cycle without shifting leaves the count alone
  assert_update_ignored_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && !shift_dr && !capture_dr) |=> $stable(bit_cnt));

  // R7: ready only in a selected shift cycle
  assert_ready_in_shift_R7: assert property (@(posedge tck) disable iff (!trst_n)
    tx_ready |-> (sel && shift_dr));

  // R9: byte completion coincides with the next take while shifting
  assert_duplex_boundary_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (rx_valid && sel && shift_dr && !capture_dr) |-> tx_ready);
endmodule

bind dbgbyte_dr dbgbyte_dr_chk #(.BYTE_W(BYTE_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .update_dr(update_dr), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .bit_cnt(bit_cnt)
);

// File: tb/tb_dbgbyte_dr.sv
module tb_dbgbyte_dr;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic       tdi = 1'b0;
  logic       tdo;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] src_q[$];      // bytes offered on the transmit port
  logic [7:0] model_q[$];    // independent mirror for expectation
  logic [7:0] rx_exp[$];
  logic [7:0] tdo_exp[$];
  bit   pop_pending = 0;
  logic [7:0] tdo_acc;
  int   tcnt = 0;

  dbgbyte_dr dut (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic refresh_tx();
    tx_valid = (src_q.size() != 0);
    tx_data  = (src_q.size() != 0) ? src_q[0] : 8'h00;
  endtask

  task automatic offer(input logic [7:0] b);
    src_q.push_back(b);
    model_q.push_back(b);
    refresh_tx();
  endtask

  function automatic logic [7:0] next_tx_exp();
    if (model_q.size() != 0) return model_q.pop_front();
    return 8'hAA;
  endfunction

  task automatic capture();
    @(negedge tck);
    capture_dr = 1'b1; shift_dr = 1'b0; update_dr = 1'b0;
    @(negedge tck);
    capture_dr = 1'b0;
  endtask

  // shift n bits of v, LSB first; caller is on a negedge
  task automatic shift_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge tck);
      shift_dr = 1'b1; tdi = v[i];
    end
    @(negedge tck);
    shift_dr = 1'b0;
  endtask

  // full bytes, scan kept in Shift-DR between them
  task automatic shift_stream(input logic [7:0] b[$]);
    foreach (b[k]) begin
      rx_exp.push_back(b[k]);
      tdo_exp.push_back(next_tx_exp());
    end
    foreach (b[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (!(k == 0 && i == 0)) @(negedge tck);
        shift_dr = 1'b1; tdi = b[k][i];
      end
    end
    @(negedge tck);
    shift_dr = 1'b0;
  endtask

  // monitor / scoreboard, sampling mid-low-phase
  always @(negedge tck) begin
    if (pop_pending) void'(src_q.pop_front());
    pop_pending = 0;
    refresh_tx();
    #5;
    if (trst_n && tx_valid && tx_ready) pop_pending = 1;
    if (trst_n && rx_valid) begin
      if (rx_exp.size() == 0) chk(0, "R2/R3/R8 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = rx_exp.pop_front();
        chk(rx_data == e, "R2 rx byte", rx_data, e);
      end
    end
    if (trst_n && sel && capture_dr) tcnt = 0;
    else if (trst_n && sel && shift_dr) begin
      tdo_acc[tcnt] = tdo;
      tcnt++;
      if (tcnt == 8) begin
        tcnt = 0;
        if (tdo_exp.size() == 0) chk(0, "R5 unexpected tdo byte", tdo_acc, 0);
        else begin
          logic [7:0] e;
          e = tdo_exp.pop_front();
          chk(tdo_acc == e, "R5/R6/R9 tdo byte", tdo_acc, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    // R1: reset state
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
    chk(tdo == 1'b0, "R1 tdo", tdo, 0);
    trst_n = 1'b1;
    sel = 1'b1;
    @(negedge tck);

    // R2, R6: command scan with nothing offered -> filler out
    capture();
    shift_stream('{8'h3C, 8'hA5, 8'h00, 8'hFF});

    // R5, R7, R9: response scan, status then data then filler
    offer(8'h80); offer(8'h01); offer(8'hF2);
    capture();
    shift_stream('{8'h00, 8'h11, 8'h22, 8'h33, 8'h44});
    chk(src_q.size() == 0, "R7 all offered bytes taken", src_q.size(), 0);

    // R7: queued byte not consumed by a scan that never shifts it
    offer(8'h6D);
    capture();
    @(negedge tck);
    chk(src_q.size() == 1, "R7 no take without shift", src_q.size(), 1);
    shift_stream('{8'h77});

    // R3: partial byte discarded by a new capture
    capture();
    void'(next_tx_exp());        // filler consumed at first partial bit
    shift_bits(8'h1F, 5);
    capture();
    shift_stream('{8'h5A});

    // R4: byte split across an Update-DR pulse
    offer(8'h96);
    capture();
    rx_exp.push_back(8'hC3);
    tdo_exp.push_back(next_tx_exp());
    shift_bits(8'hC3, 3);
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    shift_bits(8'hC3 >> 3, 5);

    // R8: deselected shifting has no effect
    offer(8'h4B);
    sel = 1'b0;
    shift_bits(8'hE7, 8);
    repeat (2) @(negedge tck);
    chk(src_q.size() == 1, "R8 no take while deselected", src_q.size(), 1);
    sel = 1'b1;
    capture();
    shift_stream('{8'h99, 8'h55});

    repeat (4) @(negedge tck);
    chk(rx_exp.size() == 0, "R2 all rx bytes seen", rx_exp.size(), 0);
    chk(tdo_exp.size() == 0, "R5 all tdo bytes seen", tdo_exp.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule